// File: doc/BRIEF.md
# Alignment-Checking Byte-Serial Memory Access Unit

This unit sits between a load/store pipeline and a byte-wide memory. It accepts one request at a time. A request carries an address, a size in bytes, a direction, a privilege level and an access kind: aligned-only or unaligned-capable. Three configuration bits come with it: an alignment-check bit, an unaligned-enable bit and a big-endian bit. A fourth bit marks the target memory as shareable.

From these inputs the unit decides whether the request is rejected, whether its address is rounded down to the size boundary, or whether it proceeds byte by byte from an arbitrary address. It then moves the bytes one at a time, in ascending address order, over a valid/ready port. Read bytes are packed into a little-endian value, and the whole value is reversed when the big-endian bit is set. Write bytes are taken from the value with the same rule.

Two side channels run alongside the data. Before each byte reaches memory, a trace strobe reports that access. Before the first byte of a write to shareable memory, a clear pulse carrying the effective address and size goes to the exclusive monitor.

Top module: `algn_mem_unit`

## Requirements
- R1: Only sizes 1, 2, 4 and 8 are legal. Any other size value on `reqSize` ends the request in the cycle after acceptance with `rspDone` and `rspBadSize` high and `rspAbort` low. No memory, trace or clear activity takes place for it.
- R2: An aligned-only request (`reqUnalOk`=0) whose address is not a multiple of its size, with `cfgAlignChk` or `cfgUnalEn` set, ends in the cycle after acceptance with `rspDone` and `rspAbort` high. No memory, trace or clear activity takes place for it.
- R3: An aligned-only request to a misaligned address with both `cfgAlignChk` and `cfgUnalEn` clear starts at the address rounded down to the size boundary.
- R4: An unaligned-capable request with both `cfgAlignChk` and `cfgUnalEn` clear is first rounded down to the size boundary, and so never aborts.
- R5: An unaligned-capable request to a misaligned address aborts as in R2 when `cfgAlignChk` is set. When only `cfgUnalEn` is set, it runs byte by byte from the unrounded address.
- R6: A legal request performs exactly `size` byte handshakes at effective address +0, +1, … in that order, with the address wrapping at the address width. With `cfgBigEnd`=0, the byte at offset i is bits [8i+7:8i] of the value. Read data above the access size is zero.
- R7: With `cfgBigEnd`=1, the byte at offset i is bits [8(size-1-i)+7:8(size-1-i)] of the value, for both reads and writes.
- R8: A write with `cfgShareable`=1 produces one `exclClr` pulse carrying the effective address and size before its first byte handshake. Reads and non-shareable writes produce none.
- R9: Each byte access raises `traceValid` exactly once, with `traceAddr` equal to that byte's address, no later than the cycle of its handshake.
- R10: `rspDone` pulses for one cycle, and for a completed request it falls in the cycle right after the last byte handshake. `reqReady` is high only while the unit is idle and never while `memValid` is high.
- R11: While `memValid` is high and `memReady` is low, `memValid`, `memAddr`, `memWrite` and `memWdata` hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Unit idle, request taken when both high |
| reqAddr | input | AW | Byte address of the request |
| reqSize | input | SW | Access size in bytes |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqPriv | input | 1 | Privileged access |
| reqUnalOk | input | 1 | 1 = unaligned-capable access kind |
| reqWdata | input | DW | Write value |
| cfgAlignChk | input | 1 | Alignment-check control |
| cfgUnalEn | input | 1 | Unaligned-enable control |
| cfgBigEnd | input | 1 | Big-endian byte order |
| cfgShareable | input | 1 | Target memory is shareable |
| memValid | output | 1 | Byte access request |
| memReady | input | 1 | Memory accepts or returns the byte |
| memAddr | output | AW | Byte address |
| memWrite | output | 1 | Byte access is a write |
| memWdata | output | 8 | Byte to write |
| memPriv | output | 1 | Privilege of the access |
| memRdata | input | 8 | Byte read, valid with memReady |
| traceValid | output | 1 | Trace entry for the current byte |
| traceAddr | output | AW | Address of the traced byte |
| traceWrite | output | 1 | Direction of the traced byte |
| exclClr | output | 1 | Clear-by-address pulse to the exclusive monitor |
| exclAddr | output | AW | Effective start address for the clear |
| exclSize | output | SW | Size for the clear |
| rspDone | output | 1 | Request finished |
| rspAbort | output | 1 | Alignment abort, with rspDone |
| rspBadSize | output | 1 | Illegal size, with rspDone |
| rspData | output | DW | Read value |

## Verification
Two activities can share a cycle. One is the trace entry for a byte. The other is that byte's memory handshake, which happens in the same cycle whenever memory is ready on the first cycle of the access. The bench alternates between a memory that is always ready and one that stalls on a pseudo-random pattern. This makes both the coincident case and the case where the trace entry leads occur for every kind of request. A bench monitor counts an error whenever a handshake completes without a trace entry recorded for it in that cycle or earlier. A second overlap pairs the exclusive-monitor clear with the start of the write bytes. The monitor also requires that the clear of a shareable write was seen before any of that write's byte handshakes.

// File: rtl/algn_mem_pkg.sv
package algn_mem_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FAULT,
    ST_CLR,
    ST_XFER,
    ST_DONE
  } ctlState_e;

  // strobes from the sequencer to the byte-lane datapath
  typedef struct packed {
    logic load;   // capture a newly accepted request
    logic step;   // one byte handshake completed
  } dpStrobe_t;

endpackage

// File: rtl/algn_mem_decode.sv
// Combinational request decode: legality of the size, alignment fault and
// the effective start address after optional rounding.
module algn_mem_decode #(
  parameter int AW   = 16,
  parameter int SW   = 4,
  parameter int MAXB = 8
) (
  input  logic [AW-1:0] addr,
  input  logic [SW-1:0] size,
  input  logic          unalOk,
  input  logic          alignChk,
  input  logic          unalEn,
  output logic          sizeOk,
  output logic          alignFault,
  output logic [AW-1:0] effAddr
);
  localparam int NLEG = $clog2(MAXB) + 1;

  logic [NLEG-1:0] legalHit;
  logic [AW-1:0]   mask;
  logic [AW-1:0]   rounded;
  logic            misIn;

  for (genvar k = 0; k < NLEG; k++) begin : g_leg
    assign legalHit[k] = (size == SW'(1 << k));
  end

  assign sizeOk  = |legalHit;
  assign mask    = sizeOk ? (AW'(size) - AW'(1)) : '0;
  assign rounded = addr & ~mask;
  assign misIn   = |(addr & mask);

  always_comb begin
    effAddr    = addr;
    alignFault = 1'b0;
    if (sizeOk) begin
      if (!unalOk) begin
        if (misIn) begin
          if (alignChk || unalEn) alignFault = 1'b1;
          else                    effAddr    = rounded;
        end
      end else begin
        if (!alignChk && !unalEn) effAddr    = rounded;
        else if (misIn && alignChk) alignFault = 1'b1;
      end
    end
  end

endmodule

// File: rtl/algn_mem_ctrl.sv
// Sequencer: accept, fault reporting, monitor clear, byte loop, done.
module algn_mem_ctrl
  import algn_mem_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      reqWrite,
  input  logic      cfgShareable,
  input  logic      sizeOk,
  input  logic      alignFault,
  input  logic      lastByte,
  input  logic      memReady,
  output logic      reqReady,
  output logic      memValid,
  output logic      traceValid,
  output logic      exclClr,
  output logic      rspDone,
  output logic      rspAbort,
  output logic      rspBadSize,
  output dpStrobe_t strobe
);
  ctlState_e state, stateNext;
  logic      faultAlign, faultSize, traced;
  logic      accept;

  assign accept      = (state == ST_IDLE) && reqValid;
  assign strobe.load = accept;
  assign strobe.step = (state == ST_XFER) && memReady;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (accept) begin
        if (!sizeOk || alignFault)       stateNext = ST_FAULT;
        else if (reqWrite && cfgShareable) stateNext = ST_CLR;
        else                             stateNext = ST_XFER;
      end
      ST_FAULT: stateNext = ST_IDLE;
      ST_CLR:   stateNext = ST_XFER;
      ST_XFER:  if (memReady && lastByte) stateNext = ST_DONE;
      ST_DONE:  stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      faultAlign <= 1'b0;
      faultSize  <= 1'b0;
      traced     <= 1'b0;
    end else begin
      state <= stateNext;
      if (accept) begin
        faultSize  <= !sizeOk;
        faultAlign <= sizeOk && alignFault;
      end
      if (state == ST_XFER) traced <= !memReady;
      else                  traced <= 1'b0;
    end
  end

  assign reqReady   = (state == ST_IDLE);
  assign memValid   = (state == ST_XFER);
  assign traceValid = (state == ST_XFER) && !traced;
  assign exclClr    = (state == ST_CLR);
  assign rspDone    = (state == ST_DONE) || (state == ST_FAULT);
  assign rspAbort   = (state == ST_FAULT) && faultAlign;
  assign rspBadSize = (state == ST_FAULT) && faultSize;

endmodule

// File: rtl/algn_mem_dp.sv
// Byte-lane datapath: address counter, lane selection with endian reversal,
// read-value assembly.
module algn_mem_dp
  import algn_mem_pkg::*;
#(
  parameter int AW   = 16,
  parameter int DW   = 64,
  parameter int SW   = 4,
  parameter int MAXB = DW / 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpStrobe_t     strobe,
  input  logic [AW-1:0] effAddr,
  input  logic [SW-1:0] size,
  input  logic          write,
  input  logic          priv,
  input  logic          bigEnd,
  input  logic [DW-1:0] wdata,
  input  logic [7:0]    memRdata,
  output logic [AW-1:0] memAddr,
  output logic          memWrite,
  output logic [7:0]    memWdata,
  output logic          memPriv,
  output logic [DW-1:0] rspData,
  output logic          lastByte,
  output logic [AW-1:0] exclAddr,
  output logic [SW-1:0] exclSize
);
  localparam int IW = $clog2(MAXB);

  logic [AW-1:0] baseAddr;
  logic [SW-1:0] idx, cnt, cntM1;
  logic          wrReg, privReg, beReg;
  logic [DW-1:0] wdReg, rdReg;
  logic [IW-1:0] laneIdx;

  assign cntM1    = cnt - SW'(1);
  assign laneIdx  = beReg ? IW'(cntM1 - idx) : IW'(idx);
  assign lastByte = (idx == cntM1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseAddr <= '0;
      idx      <= '0;
      cnt      <= SW'(1);
      wrReg    <= 1'b0;
      privReg  <= 1'b0;
      beReg    <= 1'b0;
      wdReg    <= '0;
      rdReg    <= '0;
    end else if (strobe.load) begin
      baseAddr <= effAddr;
      idx      <= '0;
      cnt      <= size;
      wrReg    <= write;
      privReg  <= priv;
      beReg    <= bigEnd;
      wdReg    <= wdata;
      rdReg    <= '0;
    end else if (strobe.step) begin
      idx <= idx + SW'(1);
      if (!wrReg) rdReg[{laneIdx, 3'b000} +: 8] <= memRdata;
    end
  end

  assign memAddr  = baseAddr + AW'(idx);
  assign memWrite = wrReg;
  assign memWdata = wdReg[{laneIdx, 3'b000} +: 8];
  assign memPriv  = privReg;
  assign rspData  = rdReg;
  assign exclAddr = baseAddr;
  assign exclSize = cnt;

endmodule

// File: rtl/algn_mem_unit.sv
module algn_mem_unit
  import algn_mem_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 64,
  parameter int SW = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  output logic          reqReady,
  input  logic [AW-1:0] reqAddr,
  input  logic [SW-1:0] reqSize,
  input  logic          reqWrite,
  input  logic          reqPriv,
  input  logic          reqUnalOk,
  input  logic [DW-1:0] reqWdata,
  input  logic          cfgAlignChk,
  input  logic          cfgUnalEn,
  input  logic          cfgBigEnd,
  input  logic          cfgShareable,
  output logic          memValid,
  input  logic          memReady,
  output logic [AW-1:0] memAddr,
  output logic          memWrite,
  output logic [7:0]    memWdata,
  output logic          memPriv,
  input  logic [7:0]    memRdata,
  output logic          traceValid,
  output logic [AW-1:0] traceAddr,
  output logic          traceWrite,
  output logic          exclClr,
  output logic [AW-1:0] exclAddr,
  output logic [SW-1:0] exclSize,
  output logic          rspDone,
  output logic          rspAbort,
  output logic          rspBadSize,
  output logic [DW-1:0] rspData
);
  localparam int MAXB = DW / 8;

  logic          sizeOk, alignFault, lastByte;
  logic [AW-1:0] effAddr;
  dpStrobe_t     strobe;

  algn_mem_decode #(.AW(AW), .SW(SW), .MAXB(MAXB)) u_decode (
    .addr(reqAddr), .size(reqSize), .unalOk(reqUnalOk),
    .alignChk(cfgAlignChk), .unalEn(cfgUnalEn),
    .sizeOk(sizeOk), .alignFault(alignFault), .effAddr(effAddr)
  );

  algn_mem_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .cfgShareable(cfgShareable), .sizeOk(sizeOk), .alignFault(alignFault),
    .lastByte(lastByte), .memReady(memReady), .reqReady(reqReady),
    .memValid(memValid), .traceValid(traceValid), .exclClr(exclClr),
    .rspDone(rspDone), .rspAbort(rspAbort), .rspBadSize(rspBadSize),
    .strobe(strobe)
  );

  algn_mem_dp #(.AW(AW), .DW(DW), .SW(SW), .MAXB(MAXB)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .effAddr(effAddr),
    .size(reqSize), .write(reqWrite), .priv(reqPriv), .bigEnd(cfgBigEnd),
    .wdata(reqWdata), .memRdata(memRdata), .memAddr(memAddr),
    .memWrite(memWrite), .memWdata(memWdata), .memPriv(memPriv),
    .rspData(rspData), .lastByte(lastByte), .exclAddr(exclAddr),
    .exclSize(exclSize)
  );

  assign traceAddr  = memAddr;
  assign traceWrite = memWrite;

endmodule

// File: rtl/algn_mem_chk.sv
module algn_mem_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rstN,
  input logic          reqReady,
  input logic          memValid,
  input logic          memReady,
  input logic [AW-1:0] memAddr,
  input logic          memWrite,
  input logic [7:0]    memWdata,
  input logic          traceValid,
  input logic          exclClr,
  input logic          rspDone,
  input logic          rspAbort,
  input logic          rspBadSize
);
  logic trPend;
  always_ff @(posedge clk) begin
    if (!rstN) trPend <= 1'b0;
    else if (memValid && memReady) trPend <= 1'b0;
    else if (traceValid) trPend <= 1'b1;
  end

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && !memReady) |=> (memValid && $stable(memAddr) &&
                                 $stable(memWrite) && $stable(memWdata)));

  assert_fault_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    (rspAbort || rspBadSize) |-> (rspDone && !memValid && !exclClr && !traceValid));

  assert_flags_R1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({rspAbort, rspBadSize}));

  assert_idle_only_R10: assert property (@(posedge clk) disable iff (!rstN)
    memValid |-> !reqReady);

  assert_done_after_last_R10: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && memReady) |=> (rspDone || memValid));

  assert_trace_first_R9: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && memReady) |-> (traceValid || trPend));

  assert_clr_apart_R8: assert property (@(posedge clk) disable iff (!rstN)
    exclClr |=> (memValid && memWrite));

endmodule

bind algn_mem_unit algn_mem_chk #(.AW(AW)) u_chk (
  .clk(clk), .rstN(rstN), .reqReady(reqReady), .memValid(memValid),
  .memReady(memReady), .memAddr(memAddr), .memWrite(memWrite),
  .memWdata(memWdata), .traceValid(traceValid), .exclClr(exclClr),
  .rspDone(rspDone), .rspAbort(rspAbort), .rspBadSize(rspBadSize)
);

// File: tb/algn_mem_unit_tb.sv
module algn_mem_unit_tb;
  localparam int AW = 8;
  localparam int DW = 64;
  localparam int SW = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic          reqValid = 1'b0, reqReady;
  logic [AW-1:0] reqAddr = '0;
  logic [SW-1:0] reqSize = '0;
  logic          reqWrite = 1'b0, reqPriv = 1'b0, reqUnalOk = 1'b0;
  logic [DW-1:0] reqWdata = '0;
  logic          cfgAlignChk = 1'b0, cfgUnalEn = 1'b0, cfgBigEnd = 1'b0, cfgShareable = 1'b0;
  logic          memValid, memReady, memWrite, memPriv;
  logic [AW-1:0] memAddr, traceAddr, exclAddr;
  logic [7:0]    memWdata, memRdata;
  logic          traceValid, traceWrite, exclClr;
  logic [SW-1:0] exclSize;
  logic          rspDone, rspAbort, rspBadSize;
  logic [DW-1:0] rspData;

  algn_mem_unit #(.AW(AW), .DW(DW), .SW(SW)) u_dut (.*);

  // memory model and monitors
  logic [7:0]  mem [256];
  logic [7:0]  lfsr;
  logic        stallMode = 1'b0;
  int          hsCnt, trCnt, clrCnt, trBad, clrBad, stabBad, cyc, lastHsCyc;
  logic [AW-1:0] hsLog [16];
  logic [AW-1:0] clrAddrLast, heldAddr;
  logic          trPend, clrSeen, holding;

  assign memRdata = mem[memAddr];
  assign memReady = stallMode ? lfsr[0] : 1'b1;

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'(i * 37 + 5);
      lfsr <= 8'hA5; hsCnt <= 0; trCnt <= 0; clrCnt <= 0; trBad <= 0;
      clrBad <= 0; stabBad <= 0; cyc <= 0; lastHsCyc <= -5;
      trPend <= 1'b0; clrSeen <= 1'b0; holding <= 1'b0; clrAddrLast <= '0;
      heldAddr <= '0;
    end else begin
      cyc  <= cyc + 1;
      lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      if (holding && (!memValid || memAddr != heldAddr)) stabBad <= stabBad + 1;
      holding  <= memValid && !memReady;
      heldAddr <= memAddr;
      if (traceValid) begin
        trCnt <= trCnt + 1;
        if (traceAddr != memAddr || traceWrite != memWrite) trBad <= trBad + 1;
      end
      if (exclClr) begin
        clrCnt <= clrCnt + 1; clrAddrLast <= exclAddr; clrSeen <= 1'b1;
      end
      if (memValid && memReady) begin
        if (memWrite) mem[memAddr] <= memWdata;
        hsLog[hsCnt[3:0]] <= memAddr;
        hsCnt <= hsCnt + 1;
        lastHsCyc <= cyc;
        if (!(trPend || traceValid)) trBad <= trBad + 1;
        if (memWrite && cfgShareable && !clrSeen) clrBad <= clrBad + 1;
        trPend <= 1'b0;
      end else if (traceValid) trPend <= 1'b1;
      if (rspDone) clrSeen <= 1'b0;
    end
  end

  int checks = 0, failures = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic runReq(input int sz, input logic [AW-1:0] addr, input bit wr,
                        input bit uo, input bit ac, input bit ue, input bit be,
                        input bit sh, input logic [DW-1:0] wd);
    bit legal, mis, fault;
    logic [AW-1:0] mask, eff;
    logic [DW-1:0] expVal;
    int h0, t0, c0, tb0, cb0, n;
    string tagA, tagD;
    legal = (sz == 1) || (sz == 2) || (sz == 4) || (sz == 8);
    mask  = legal ? AW'(sz - 1) : '0;
    mis   = (addr & mask) != 0;
    eff   = addr;
    fault = 1'b0;
    if (legal) begin
      if (!uo) begin
        if (mis) begin if (ac || ue) fault = 1'b1; else eff = addr & ~mask; end
      end else begin
        if (!ac && !ue) eff = addr & ~mask;
        else if (mis && ac) fault = 1'b1;
      end
    end
    tagA = !uo ? "R3" : ((ac || ue) ? "R5" : "R4");
    tagD = be ? "R7" : "R6";
    expVal = '0;
    if (legal && !wr)
      for (int i = 0; i < sz; i++)
        expVal[(be ? (sz - 1 - i) : i) * 8 +: 8] = mem[AW'(eff + AW'(i))];
    h0 = hsCnt; t0 = trCnt; c0 = clrCnt; tb0 = trBad; cb0 = clrBad;
    @(negedge clk);
    check(reqReady == 1'b1, "R10", "reqReady idle", reqReady, 1);
    reqValid = 1'b1; reqAddr = addr; reqSize = SW'(sz); reqWrite = wr;
    reqPriv = addr[0]; reqUnalOk = uo; reqWdata = wd; cfgAlignChk = ac;
    cfgUnalEn = ue; cfgBigEnd = be; cfgShareable = sh;
    @(negedge clk);
    reqValid = 1'b0;
    n = 0;
    while (!rspDone && n < 200) begin
      @(negedge clk); n++;
    end
    check(rspDone == 1'b1, "R10", "done seen", rspDone, 1);
    if (!legal) begin
      check(n == 0 && rspBadSize && !rspAbort, "R1", "bad size response",
            {n[7:0], rspBadSize, rspAbort}, 2);
      check(hsCnt == h0 && trCnt == t0 && clrCnt == c0, "R1", "no activity",
            hsCnt - h0 + trCnt - t0 + clrCnt - c0, 0);
    end else if (fault) begin
      check(n == 0 && rspAbort && !rspBadSize, uo ? "R5" : "R2", "abort response",
            {n[7:0], rspAbort, rspBadSize}, 2);
      check(hsCnt == h0 && trCnt == t0 && clrCnt == c0, "R2", "no activity",
            hsCnt - h0 + trCnt - t0 + clrCnt - c0, 0);
    end else begin
      check(!rspAbort && !rspBadSize, "R10", "clean done", {rspAbort, rspBadSize}, 0);
      check(hsCnt - h0 == sz, "R6", "byte count", hsCnt - h0, sz);
      check(cyc == lastHsCyc + 1, "R10", "done after last byte", cyc, lastHsCyc + 1);
      for (int i = 0; i < sz && i < 16; i++)
        check(hsLog[(h0 + i) % 16] == AW'(eff + AW'(i)), tagA, "byte address",
              hsLog[(h0 + i) % 16], AW'(eff + AW'(i)));
      check(trCnt - t0 == sz && trBad == tb0, "R9", "trace entries",
            trCnt - t0 + 100 * (trBad - tb0), sz);
      check(clrCnt - c0 == ((wr && sh) ? 1 : 0) && clrBad == cb0, "R8", "monitor clear",
            clrCnt - c0 + 100 * (clrBad - cb0), (wr && sh) ? 1 : 0);
      if (wr && sh)
        check(clrAddrLast == eff, "R8", "clear address", clrAddrLast, eff);
      if (!wr)
        check(rspData == expVal, tagD, "read value", rspData, expVal);
      else
        for (int i = 0; i < sz; i++)
          check(mem[AW'(eff + AW'(i))] == wd[(be ? (sz - 1 - i) : i) * 8 +: 8], tagD,
                "written byte", mem[AW'(eff + AW'(i))], wd[(be ? (sz - 1 - i) : i) * 8 +: 8]);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures + 1);
    $finish;
  end

  initial begin
    int sizes[7] = '{0, 1, 2, 3, 4, 5, 8};
    int k;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady && !memValid && !rspDone && !exclClr && !traceValid, "R10",
          "reset state", {reqReady, memValid, rspDone, exclClr, traceValid}, 5'b10000);
    k = 0;
    for (int s = 0; s < 7; s++)
      for (int off = 0; off < 8; off++)
        for (int mode = 0; mode < 32; mode++) begin
          stallMode = k[0];
          runReq(sizes[s], AW'(k * 24 + off), mode[0], mode[1], mode[2], mode[3],
                 mode[4], off[0] ^ mode[4],
                 {8{8'(k)}} ^ 64'h0123_4567_89AB_CDEF);
          k++;
        end
    check(stabBad == 0, "R11", "held byte request", stabBad, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule